// File: doc/BRIEF.md
# Cascaded Dual Priority Interrupt Controller

Two eight-input priority interrupt controllers are joined as a primary/secondary pair, so that fifteen request lines can reach one processor interrupt pin. Each controller keeps a request bit, an in-service bit and a mask bit for every line. It resolves a fixed priority, where input 0 is the highest. It hands the processor an 8-bit vector when the processor acknowledges. The secondary controller's interrupt output drives primary input 2. A request from the secondary therefore competes at the priority of that primary input.

Software uses a small write port to program each controller. The write port sets the mask, the per-line trigger mode, the vector base and a non-specific end-of-interrupt command. A read port brings back the request, in-service, mask and mode registers. Some sources are active-low. They are inverted at the block's edge, so inside the block a high level always means a request. A few lines have a fixed role: they are locked to edge mode or are tied off as reserved.

Top module: `pic_cascade_pair`

## Requirements
- R1: After reset, the request and in-service registers of both controllers read 0, the masks read 0xFF, the modes read 0 (edge), and int_o is low.
- R2: In edge mode (mode bit 0), a rising input is latched into the request bit. The bit stays set after the input falls and is cleared only when that line is acknowledged.
- R3: In level mode (mode bit 1), the request bit follows the input one clock later. It clears when the input drops, even if the line was never acknowledged.
- R4: A masked line (mask bit 1) still sets its request bit. It never raises int_o and is never moved to in-service.
- R5: Among unmasked pending requests, the lowest line number wins. All secondary lines share the priority of primary input 2, so secondary line 2 (irq_in[10]) beats primary line 3.
- R6: An acknowledge while int_o is high moves the winner from request to in-service. After that clock edge, vec_o equals the base (wr_data[7:3] written to register 2) with the line number in bits 2:0.
- R7: When the primary winner is input 2, one acknowledge sets primary in-service bit 2 and the secondary winner's in-service bit. vec_o then carries the secondary base with the secondary line number.
- R8: Writing register 3 with data bit 5 set clears the lowest-numbered set in-service bit of the selected controller, and only that bit.
- R9: A line in service holds off int_o for lines of equal or lower priority until its end-of-interrupt.
- R10: Primary lines 0 and 2 and secondary line 0 (irq_in[8]) are locked to edge mode. Mode writes to these lines are ignored, and their mode bits read back 0.
- R11: irq_in[1], irq_in[2] and irq_in[13] never set any request bit and never raise int_o. Line 2 is used only by the cascade.
- R12: irq_in[8] is active-low. A falling edge on it is a request on secondary line 0, returned with vector secondary base + 0.
- R13: An acknowledge while int_o is low returns the primary base with bits 2:0 = 7 and changes no register.
- R14: An end-of-interrupt command and an acknowledge in the same cycle both take effect. The lowest in-service bit is cleared and the new winner is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Request lines; bit n is line n, bits 0-7 primary, 8-15 secondary |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 primary, 1 secondary |
| wr_addr | input | 2 | 0 mask, 1 mode, 2 vector base, 3 command |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 primary, 1 secondary |
| rd_addr | input | 2 | 0 request, 1 in-service, 2 mask, 3 mode |
| rd_data | output | 8 | Read data, combinational |
| ack_i | input | 1 | One-cycle acknowledge pulse |
| int_o | output | 1 | Interrupt to the processor |
| vec_o | output | 8 | Vector, registered at each acknowledge |

## Verification
The acknowledge and the end-of-interrupt command both rewrite the in-service register. They can land in the same clock edge. The bench provokes this case as follows. It puts primary line 3 in service, then raises line 0 so that int_o returns. It then drives the end-of-interrupt write and the acknowledge pulse in one cycle. The bench expects vector base+0 and an in-service register of exactly bit 0: the old bit 3 is gone and the new bit 0 is present.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      WR_MASK = 2'd0,
      WR_MODE = 2'd1,
      WR_BASE = 2'd2,
      WR_CMD  = 2'd3
   } wr_reg_e;

   typedef enum logic [1:0] {
      RD_REQ  = 2'd0,
      RD_SERV = 2'd1,
      RD_MASK = 2'd2,
      RD_MODE = 2'd3
   } rd_reg_e;

   localparam int unsigned EOI_BIT = 5;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int unsigned N  = 8,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  vec_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      found_o = |vec_i;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
   import pic_pkg::*;
#(
   parameter int unsigned   N         = 8,
   parameter int unsigned   VEC_W     = 8,
   parameter logic [N-1:0]  LOCK_EDGE = '0,
   localparam int unsigned  IW        = $clog2(N),
   localparam int unsigned  BW        = VEC_W - IW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     line_in,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [VEC_W-1:0] wr_data,
   input  logic             ack_i,
   output logic             int_o,
   output logic [VEC_W-1:0] vec_o,
   output logic [N-1:0]     irr_o,
   output logic [N-1:0]     isr_o,
   output logic [N-1:0]     imr_o,
   output logic [N-1:0]     mode_o
);
   if ((1 << IW) != N || N < 2) begin : g_bad_lines
      $error("pic_unit: N must be a power of two, at least 2");
   end
   if (N > VEC_W) begin : g_bad_width
      $error("pic_unit: N must not exceed VEC_W");
   end

   logic [N-1:0]    irr_q, isr_q, imr_q, mode_q, prev_q;
   logic [BW-1:0]   base_q;
   logic [N-1:0]    cand, grant, eoi_clr;
   logic            c_found, s_found;
   logic [IW-1:0]   c_idx, s_idx;
   logic            mode_wr, eoi;

   assign mode_wr = wr_en && (wr_addr == WR_MODE);
   assign eoi     = wr_en && (wr_addr == WR_CMD) && wr_data[EOI_BIT];
   assign cand    = irr_q & ~imr_q;

   pic_prio #(.N(N)) i_cand_prio (.vec_i(cand),  .found_o(c_found), .idx_o(c_idx));
   pic_prio #(.N(N)) i_serv_prio (.vec_i(isr_q), .found_o(s_found), .idx_o(s_idx));

   assign int_o = c_found && (!s_found || (c_idx < s_idx));
   assign vec_o = int_o ? {base_q, c_idx} : {base_q, {IW{1'b1}}};

   always_comb begin
      grant   = '0;
      eoi_clr = '0;
      if (ack_i && int_o) grant[c_idx]   = 1'b1;
      if (eoi && s_found) eoi_clr[s_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q  <= '0;
         imr_q  <= '1;
         base_q <= '0;
         prev_q <= '0;
      end else begin
         isr_q  <= (isr_q & ~eoi_clr) | grant;
         prev_q <= line_in;
         if (wr_en && wr_addr == WR_MASK) imr_q  <= wr_data[N-1:0];
         if (wr_en && wr_addr == WR_BASE) base_q <= wr_data[VEC_W-1:IW];
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      if (LOCK_EDGE[i]) begin : g_locked
         assign mode_q[i] = 1'b0;
      end else begin : g_prog
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       mode_q[i] <= 1'b0;
            else if (mode_wr) mode_q[i] <= wr_data[i];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         irr_q[i] <= 1'b0;
         else if (mode_q[i]) irr_q[i] <= line_in[i];
         else                irr_q[i] <= (irr_q[i] & ~grant[i]) | (line_in[i] & ~prev_q[i]);
      end

      // R2: a latched edge request survives until its own grant
      p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (irr_q[i] && !mode_q[i] && !grant[i] && !mode_wr) |=> irr_q[i]);
      // R3: level request tracks the input one clock later
      p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[i] && !mode_wr) |=> (irr_q[i] == $past(line_in[i])));
   end

   assign irr_o  = irr_q;
   assign isr_o  = isr_q;
   assign imr_o  = imr_q;
   assign mode_o = mode_q;

   // R4: nothing masked ever enters service
   p_no_masked_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> (((isr_q & ~$past(isr_q)) & $past(imr_q)) == '0));
   // R6: at most one line enters service per acknowledge
   p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(isr_q & ~$past(isr_q)));
   // R8: an end-of-interrupt without a grant removes exactly one bit
   p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && (isr_q != '0) && !ack_i) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/pic_cascade_pair.sv
module pic_cascade_pair
   import pic_pkg::*;
#(
   parameter int unsigned           LINES      = 8,
   parameter int unsigned           VEC_W      = 8,
   parameter int unsigned           CASC_LINE  = 2,
   parameter logic [2*LINES-1:0]    ACTIVE_LOW = 16'h0100,
   parameter logic [2*LINES-1:0]    RESERVED   = 16'h2002,
   parameter logic [LINES-1:0]      P_LOCK     = 8'h05,
   parameter logic [LINES-1:0]      S_LOCK     = 8'h01,
   localparam int unsigned          IW         = $clog2(LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*LINES-1:0]   irq_in,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic [1:0]           wr_addr,
   input  logic [VEC_W-1:0]     wr_data,
   input  logic                 rd_sel,
   input  logic [1:0]           rd_addr,
   output logic [VEC_W-1:0]     rd_data,
   input  logic                 ack_i,
   output logic                 int_o,
   output logic [VEC_W-1:0]     vec_o
);
   if (CASC_LINE >= LINES) begin : g_bad_casc
      $error("pic_cascade_pair: CASC_LINE out of range");
   end
   if (!P_LOCK[CASC_LINE]) begin : g_bad_lock
      $error("pic_cascade_pair: cascade input must be edge-locked");
   end

   logic [2*LINES-1:0] phys;
   logic [LINES-1:0]   p_in, s_in;
   logic               p_int, s_int, s_ack;
   logic [VEC_W-1:0]   p_vec, s_vec, vec_q;
   logic [LINES-1:0]   p_irr, p_isr, p_imr, p_mode;
   logic [LINES-1:0]   s_irr, s_isr, s_imr, s_mode;
   logic               take_s;

   assign phys = (irq_in ^ ACTIVE_LOW) & ~RESERVED;
   assign s_in = phys[2*LINES-1:LINES];

   always_comb begin
      for (int i = 0; i < LINES; i++) p_in[i] = phys[i];
      p_in[CASC_LINE] = s_int;
   end

   pic_unit #(.N(LINES), .VEC_W(VEC_W), .LOCK_EDGE(P_LOCK)) i_primary (
      .clk(clk), .rst_n(rst_n), .line_in(p_in),
      .wr_en(wr_en && !wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
      .ack_i(ack_i), .int_o(p_int), .vec_o(p_vec),
      .irr_o(p_irr), .isr_o(p_isr), .imr_o(p_imr), .mode_o(p_mode));

   pic_unit #(.N(LINES), .VEC_W(VEC_W), .LOCK_EDGE(S_LOCK)) i_secondary (
      .clk(clk), .rst_n(rst_n), .line_in(s_in),
      .wr_en(wr_en && wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
      .ack_i(s_ack), .int_o(s_int), .vec_o(s_vec),
      .irr_o(s_irr), .isr_o(s_isr), .imr_o(s_imr), .mode_o(s_mode));

   assign take_s = p_int && (p_vec[IW-1:0] == IW'(CASC_LINE));
   assign s_ack  = ack_i && take_s;
   assign int_o  = p_int;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vec_q <= '0;
      else if (ack_i) vec_q <= take_s ? s_vec : p_vec;
   end
   assign vec_o = vec_q;

   always_comb begin
      unique case (rd_addr)
         RD_REQ:  rd_data = VEC_W'(rd_sel ? s_irr  : p_irr);
         RD_SERV: rd_data = VEC_W'(rd_sel ? s_isr  : p_isr);
         RD_MASK: rd_data = VEC_W'(rd_sel ? s_imr  : p_imr);
         default: rd_data = VEC_W'(rd_sel ? s_mode : p_mode);
      endcase
   end

   // R13: acknowledge with no interrupt yields the all-ones line code
   p_spurious_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !p_int) |=> (vec_o[IW-1:0] == {IW{1'b1}}));
   // R7: a cascade grant with a live secondary puts a secondary line in service
   p_casc_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && take_s && s_int) |=> (s_isr != '0 && p_isr[CASC_LINE]));
endmodule

// File: tb/test_pic_cascade_pair.sv
module test_pic_cascade_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_in = 16'h0100;
   logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, ack_i = 1'b0;
   logic [1:0]  wr_addr = '0, rd_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data, vec_o;
   logic        int_o;
   int          n_chk = 0, n_err = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   pic_cascade_pair i_pic_cascade_pair (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(rd_sel), .rd_addr(rd_addr),
      .rd_data(rd_data), .ack_i(ack_i), .int_o(int_o), .vec_o(vec_o));

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(bit sel, logic [1:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [7:0] rd(bit sel, logic [1:0] a);
      rd_sel = sel; rd_addr = a;
      return 8'h00;
   endfunction

   task automatic rdv(bit sel, logic [1:0] a, output logic [7:0] v);
      v = rd(sel, a);
      #1 v = rd_data;
   endtask

   task automatic ack();
      ack_i = 1'b1;
      @(posedge clk); @(negedge clk);
      ack_i = 1'b0;
   endtask

   task automatic pulse(logic [15:0] m);
      irq_in = irq_in ^ m;
      @(posedge clk); @(negedge clk);
      irq_in = irq_in ^ m;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic eoi(bit sel);
      wr(sel, 2'd3, 8'h20);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      for (int s = 0; s < 2; s++) begin
         rdv(s[0], 2'd0, v); chk("R1 request", v, 8'h00);
         rdv(s[0], 2'd1, v); chk("R1 in-service", v, 8'h00);
         rdv(s[0], 2'd2, v); chk("R1 mask", v, 8'hFF);
         rdv(s[0], 2'd3, v); chk("R1 mode", v, 8'h00);
      end
      chk("R1 int_o", {7'd0, int_o}, 8'h00);
   endtask

   task automatic t_edge();
      logic [7:0] v;
      pulse(16'h0010); idle(2);
      rdv(0, 2'd0, v); chk("R2 latched after input fell", v, 8'h10);
      chk("R2 int_o", {7'd0, int_o}, 8'h01);
      ack();
      chk("R6 vector line 4", vec_o, 8'h24);
      rdv(0, 2'd1, v); chk("R6 in-service", v, 8'h10);
      rdv(0, 2'd0, v); chk("R2 cleared by ack", v, 8'h00);
      pulse(16'h0001); idle(1);
      ack();
      chk("R6 nested vector line 0", vec_o, 8'h20);
      rdv(0, 2'd1, v); chk("R6 nested in-service", v, 8'h11);
      eoi(0);
      rdv(0, 2'd1, v); chk("R8 lowest bit cleared", v, 8'h10);
      eoi(0);
      rdv(0, 2'd1, v); chk("R8 second eoi", v, 8'h00);
   endtask

   task automatic t_level();
      logic [7:0] v;
      wr(0, 2'd1, 8'h08);
      irq_in[3] = 1'b1; idle(2);
      rdv(0, 2'd0, v); chk("R3 level follows high", v, 8'h08);
      irq_in[3] = 1'b0; idle(2);
      rdv(0, 2'd0, v); chk("R3 level follows low", v, 8'h00);
      chk("R3 int_o dropped", {7'd0, int_o}, 8'h00);
      wr(0, 2'd1, 8'h00);
   endtask

   task automatic t_mask();
      logic [7:0] v;
      wr(0, 2'd0, 8'h40);
      pulse(16'h0040); idle(2);
      rdv(0, 2'd0, v); chk("R4 masked still requests", v, 8'h40);
      chk("R4 masked no int_o", {7'd0, int_o}, 8'h00);
      ack();
      chk("R13 spurious vector", vec_o, 8'h27);
      rdv(0, 2'd1, v); chk("R13 in-service unchanged", v, 8'h00);
      rdv(0, 2'd0, v); chk("R13 request unchanged", v, 8'h40);
      wr(0, 2'd0, 8'h00);
      chk("R4 unmask raises int_o", {7'd0, int_o}, 8'h01);
      ack();
      chk("R4 vector after unmask", vec_o, 8'h26);
      eoi(0);
   endtask

   task automatic t_prio();
      logic [7:0] v;
      pulse(16'h0488); idle(2);
      ack();
      chk("R5 secondary line 2 beats primary 3", vec_o, 8'h2A);
      chk("R9 lower lines held off", {7'd0, int_o}, 8'h00);
      eoi(1); eoi(0); idle(1);
      chk("R9 int_o after eoi", {7'd0, int_o}, 8'h01);
      ack();
      chk("R5 line 3 next", vec_o, 8'h23);
      chk("R9 line 7 held off by 3", {7'd0, int_o}, 8'h00);
      eoi(0);
      ack();
      chk("R5 line 7 last", vec_o, 8'h27);
      eoi(0);
      rdv(0, 2'd0, v); chk("R5 requests drained", v, 8'h00);
   endtask

   task automatic t_cascade();
      logic [7:0] v;
      pulse(16'h1000); idle(2);
      ack();
      chk("R7 secondary vector", vec_o, 8'h2C);
      rdv(0, 2'd1, v); chk("R7 primary in-service bit 2", v, 8'h04);
      rdv(1, 2'd1, v); chk("R7 secondary in-service", v, 8'h10);
      eoi(1);
      rdv(1, 2'd1, v); chk("R8 secondary eoi", v, 8'h00);
      rdv(0, 2'd1, v); chk("R8 primary kept", v, 8'h04);
      eoi(0);
      rdv(0, 2'd1, v); chk("R8 primary eoi", v, 8'h00);
   endtask

   task automatic t_locked();
      logic [7:0] v;
      wr(0, 2'd1, 8'hFF);
      rdv(0, 2'd1, v);
      rdv(0, 2'd3, v); chk("R10 primary locked lines", v, 8'hFA);
      wr(1, 2'd1, 8'hFF);
      rdv(1, 2'd3, v); chk("R10 secondary locked line", v, 8'hFE);
      wr(0, 2'd1, 8'h00); wr(1, 2'd1, 8'h00);
   endtask

   task automatic t_reserved();
      logic [7:0] v;
      pulse(16'h2006); idle(2);
      rdv(0, 2'd0, v); chk("R11 primary requests", v, 8'h00);
      rdv(1, 2'd0, v); chk("R11 secondary requests", v, 8'h00);
      chk("R11 int_o", {7'd0, int_o}, 8'h00);
   endtask

   task automatic t_active_low();
      logic [7:0] v;
      pulse(16'h0100); idle(2);
      chk("R12 int_o from low level", {7'd0, int_o}, 8'h01);
      ack();
      chk("R12 vector", vec_o, 8'h28);
      rdv(1, 2'd1, v); chk("R12 secondary in-service", v, 8'h01);
      eoi(1); eoi(0);
   endtask

   task automatic t_same_cycle();
      logic [7:0] v;
      pulse(16'h0008); idle(1);
      ack();
      chk("R14 setup vector", vec_o, 8'h23);
      pulse(16'h0001); idle(1);
      chk("R14 line 0 preempts", {7'd0, int_o}, 8'h01);
      wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 2'd3; wr_data = 8'h20; ack_i = 1'b1;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; ack_i = 1'b0;
      chk("R14 vector", vec_o, 8'h20);
      rdv(0, 2'd1, v); chk("R14 in-service", v, 8'h01);
      eoi(0);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      wr(0, 2'd2, 8'h20); wr(1, 2'd2, 8'h28);
      wr(0, 2'd0, 8'h00); wr(1, 2'd0, 8'h00);
      t_edge();
      t_level();
      t_mask();
      t_prio();
      t_cascade();
      t_locked();
      t_reserved();
      t_active_low();
      t_same_cycle();
      summary();
   end
endmodule